// File: doc/BRIEF.md
# Serial Channel Latch with Status Readback

This block is a three-wire serial slave that sets eight on/off channel controls and, in the same transfer, reports per-channel health. A host lowers the active-low select, clocks a command word in MSB first on the serial clock rising edges, and raises the select to commit that word to the channel control register. While the word goes in, a status word leaves on the serial data output. That status word is captured when the select falls. Each status bit repeats the bit currently commanded for its channel when the channel is healthy, and gives the inverse of that bit when the external fault input for the channel is set.

The serial pins are not used as clocks. A fast system clock samples them through a synchronizer, and edges are detected in that domain, so the system clock must run at least four times the serial clock. Each commit also produces a one-cycle clear strobe, which the external fault logic uses to drop its latched faults.

Top module: `spi_out_latch`

## Requirements
- R1: During and after reset, `ctrl_o` is all zeros, `dout_o` is 0 and `clr_o` is 0.
- R2: The frame is 8 bits, received MSB first. Received bit 7 drives `ctrl_o[7]` (channel 8) and bit 0 drives `ctrl_o[0]` (channel 1).
- R3: `ctrl_o` takes the shift register contents on a rising edge of select, whatever the serial clock level. It holds its previous value for the whole time select is low.
- R4: When select falls, the shift register loads status, where bit i = `ctrl_o[i] XOR fault_i[i]`. Status bit 7 appears on `dout_o` first, and each following bit appears after a serial clock falling edge.
- R5: While select is high, serial clock and data input transitions change neither `ctrl_o` nor `dout_o`. `dout_o` then shows shift-register bit 7, which is the first of the last eight bits received.
- R6: If a frame carries more or fewer than 8 clocks, only the last 8 bits in the shift register are kept. On a short frame this includes low status bits left over from the load.
- R7: Each rising edge of select produces exactly one `clr_o` pulse, one system clock wide. `clr_o` is never high while select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x serial clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| cs_n_i | input | 1 | Active-low frame select |
| din_i | input | 1 | Serial command data |
| dout_o | output | 1 | Serial status data |
| fault_i | input | NCH | Per-channel fault indication |
| ctrl_o | output | NCH | Channel control register |
| clr_o | output | 1 | One-cycle strobe to clear latched faults |

## Verification
The hardest case to reach from the ports is a frame with the wrong length. A short frame leaves some status bits in the committed word, so the result depends on the status loaded at select fall, which in turn depends on the previous command and the fault pattern. The bench builds up a known command through full frames, holds a chosen fault vector, and then sends 5-clock and 11-clock frames. It predicts the committed word from its own model of that earlier state.

// File: rtl/spi_latch_pkg.sv
package spi_latch_pkg;
  localparam int unsigned DEF_NCH = 8;
  localparam int unsigned DEF_SYNC = 2;
  // positions inside the synchronized pin bundle
  localparam int unsigned PIN_SCLK = 0;
  localparam int unsigned PIN_CS = 1;
  localparam int unsigned PIN_DIN = 2;
  localparam int unsigned PIN_W = 3;
endpackage

// File: rtl/sync_bank.sv
module sync_bank #(
  parameter int unsigned W = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st[g] <= RST;
        else st[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) st[g] <= RST;
        else st[g] <= st[g-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [NCH-1:0] load_val_i,
  input  logic           shift_i,
  input  logic           bit_i,
  output logic [NCH-1:0] sr_o
);
  logic [NCH-1:0] sr_q;

  // load wins over shift when both land in one cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sr_q <= '0;
    else if (load_i) sr_q <= load_val_i;
    else if (shift_i) sr_q <= {sr_q[NCH-2:0], bit_i};

  assign sr_o = sr_q;
endmodule

// File: rtl/spi_out_latch.sv
module spi_out_latch #(
  parameter int unsigned NCH = spi_latch_pkg::DEF_NCH,
  parameter int unsigned SYNC_STAGES = spi_latch_pkg::DEF_SYNC
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sclk_i,
  input  logic           cs_n_i,
  input  logic           din_i,
  output logic           dout_o,
  input  logic [NCH-1:0] fault_i,
  output logic [NCH-1:0] ctrl_o,
  output logic           clr_o
);
  import spi_latch_pkg::*;

  localparam logic [PIN_W-1:0] PIN_RST = PIN_W'(1) << PIN_CS;

  logic [PIN_W-1:0] pins_s;
  logic sclk_s, cs_s, din_s;
  logic sclk_d, cs_d;
  logic cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic [NCH-1:0] sr, status, ctrl_q;
  logic dout_q, clr_q;

  sync_bank #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST(PIN_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({din_i, cs_n_i, sclk_i}),
    .q_o   (pins_s)
  );

  assign sclk_s = pins_s[PIN_SCLK];
  assign cs_s   = pins_s[PIN_CS];
  assign din_s  = pins_s[PIN_DIN];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s;
    end

  assign cs_fall   = cs_d & ~cs_s;
  assign cs_rise   = ~cs_d & cs_s;
  assign sclk_rise = sclk_s & ~sclk_d & ~cs_s & ~cs_fall;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_s & ~cs_fall;

  // healthy channel echoes its command, faulted one returns the inverse
  assign status = ctrl_q ^ fault_i;

  frame_shifter #(.NCH(NCH)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cs_fall),
    .load_val_i(status),
    .shift_i   (sclk_rise),
    .bit_i     (din_s),
    .sr_o      (sr)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      ctrl_q <= '0;
      clr_q  <= 1'b0;
    end else begin
      clr_q <= cs_rise;
      if (cs_rise) ctrl_q <= sr;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) dout_q <= 1'b0;
    else if (cs_fall) dout_q <= status[NCH-1];
    else if (cs_s || sclk_fall) dout_q <= sr[NCH-1];

  assign ctrl_o = ctrl_q;
  assign clr_o  = clr_q;
  assign dout_o = dout_q;
endmodule

// File: rtl/spi_out_latch_chk.sv
module spi_out_latch_chk #(
  parameter int unsigned NCH = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           cs_s_i,
  input logic           clr_o,
  input logic           dout_o,
  input logic [NCH-1:0] ctrl_o
);
  // R7
  clr_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |=> !clr_o);

  // R7
  clr_cs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_o |-> cs_s_i);

  // R3
  ctrl_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> clr_o);

  // R5
  dout_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s_i && $past(cs_s_i) && $past(cs_s_i, 2)) |-> $stable(dout_o));

  // R1
  always_comb
    if (!rst_ni) rst_state_chk: assert (ctrl_o == '0 && !clr_o && !dout_o);
endmodule

bind spi_out_latch spi_out_latch_chk #(.NCH(NCH)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cs_s_i(cs_s),
  .clr_o (clr_o),
  .dout_o(dout_o),
  .ctrl_o(ctrl_o)
);

// File: tb/tb_spi_out_latch.sv
module tb_spi_out_latch;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic dout, clr;
  logic [7:0] fault = '0;
  logic [7:0] ctrl;
  int total = 0, bad = 0, clr_cnt = 0;

  always #2 clk = ~clk;

  spi_out_latch dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_n_i(cs_n), .din_i(din),
    .dout_o(dout), .fault_i(fault), .ctrl_o(ctrl), .clr_o(clr)
  );

  always @(posedge clk) if (clr) clr_cnt++;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // sends n bits of tx MSB first, returns sampled dout bits
  task automatic frame(input logic [15:0] tx, input int n, input logic [7:0] hold,
                       output logic [15:0] rx);
    rx = '0;
    cs_n = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      din = tx[i];
      tick(4);
      rx = {rx[14:0], dout};
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
      if (i == n / 2) chk("R3 hold while low", 16'(ctrl), 16'(hold));
    end
    tick(4);
    cs_n = 1'b1;
    tick(6);
  endtask

  localparam logic [15:0] VEC [6] = '{
    16'hA5_00, 16'h3C_00, 16'hFF_81, 16'h00_FF, 16'h5A_0F, 16'hC3_24
  };

  initial begin
    #800000;
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 16'h0, 16'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] model, st;
    logic [15:0] rx;
    int c0;
    tick(3);
    // R1
    chk("R1 ctrl", 16'(ctrl), 16'h0);
    chk("R1 dout", 16'(dout), 16'h0);
    chk("R1 clr", 16'(clr), 16'h0);
    rst_ni = 1'b1;
    tick(4);
    chk("R1 ctrl after", 16'(ctrl), 16'h0);
    model = '0;

    for (int v = 0; v < 6; v++) begin
      fault = VEC[v][7:0];
      st = model ^ fault;
      c0 = clr_cnt;
      frame({8'h00, VEC[v][15:8]}, 8, model, rx);
      chk("R4 status", rx & 16'h00FF, 16'(st));
      chk("R2 commit", 16'(ctrl), 16'(VEC[v][15:8]));
      chk("R5 idle dout", 16'(dout), 16'(VEC[v][15]));
      chk("R7 one clr", 16'(clr_cnt - c0), 16'h1);
      model = VEC[v][15:8];
    end

    // R2 channel mapping: only bit 0 set drives channel 1
    fault = '0;
    frame(16'h0001, 8, model, rx);
    chk("R2 ch1", 16'(ctrl), 16'h0001);
    model = 8'h01;

    // R5 ignore serial activity while select high
    c0 = clr_cnt;
    for (int i = 0; i < 10; i++) begin
      din = i[0];
      sclk = ~sclk;
      tick(4);
    end
    sclk = 1'b0;
    tick(4);
    chk("R5 ctrl unchanged", 16'(ctrl), 16'(model));
    chk("R5 dout unchanged", 16'(dout), 16'h0);
    chk("R7 no clr idle", 16'(clr_cnt - c0), 16'h0);

    // R6 short frame keeps leftover status bits
    frame(16'h00B6, 8, model, rx);
    model = 8'hB6;
    fault = 8'h5A;
    st = model ^ fault;
    frame(16'h0013, 5, model, rx);
    chk("R6 short commit", 16'(ctrl), 16'({st[2:0], 5'h13}));
    chk("R4 short status", rx & 16'h001F, 16'(st[7:3]));
    model = {st[2:0], 5'h13};

    // R6 long frame keeps last eight
    fault = 8'h0F;
    st = model ^ fault;
    frame(16'h05C9, 11, model, rx);
    chk("R6 long commit", 16'(ctrl), 16'h00C9);
    chk("R4 long status", (rx >> 3) & 16'h00FF, 16'(st));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule